// File: doc/BRIEF.md
# Frame Thread Continuation Scheduler

This block picks the next short thread to run inside one activation frame. It holds a last-in first-out stack of pending thread start addresses and a bank of synchronization counters, each with a thread address attached. Commands arrive on one port, at most one per cycle. Forking a thread stores its start address on the stack. Ending a thread takes the most recent address off the stack and presents it as the next program counter. A post command counts down a named counter, and the thread attached to that counter becomes pending only when the count reaches zero.

Below every stored entry there is an implicit frame-exit entry. When a thread ends and nothing is pending, the scheduler dispatches the exit handler address and flags that the frame is finished, so that surrounding logic can swap the frame out. The exit entry cannot be removed, so the frame can be left again and again. A combined fork-and-stop command hands the forked address straight to the output and does not touch the stack. Every output is registered, so a command's result appears in the cycle after the command is accepted.

Opcode encoding on `cmd_op`: 0 no-op, 1 fork, 2 stop, 3 fork-and-stop, 4 post, 5 counter init. Codes 6 and 7 act as no-ops.

Top module: `frame_thread_sched`

## Requirements
- R1: A fork (opcode 1) with a stack that is not full pushes `cmd_addr` and dispatches nothing (`next_valid` stays low).
- R2: A stop (opcode 2) with a non-empty stack pops the most recently pushed address. One cycle later `next_valid` is high and `next_pc` holds that address.
- R3: A stop on an empty stack dispatches `EXIT_PC` and pulses `frame_done` with `next_valid`. The stack stays empty, and a later stop on the empty stack does the same again.
- R4: An init (opcode 5) loads counter `cmd_idx` with `cmd_count` and attaches `cmd_addr` to it as its thread address.
- R5: A post (opcode 4) to a counter that holds 1 brings it to zero and pushes the attached address. No dispatch happens.
- R6: A post to a counter that holds more than 1 decrements it. Nothing is pushed or dispatched.
- R7: A post to a counter that is already zero changes nothing.
- R8: A push (from a fork or from a post reaching zero) while DEPTH-1 addresses are stored pulses `overflow_err` and leaves the stack contents unchanged. A counter that a post brings to zero still stays at zero.
- R9: A fork-and-stop (opcode 3) dispatches `cmd_addr` one cycle later and leaves the stack unchanged.
- R10: After reset the stack is empty, all counters are zero and all outputs are low.
- R11: A cycle with `cmd_valid` low, or with a no-op code, changes no state and dispatches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (encoding above) |
| cmd_addr | input | AW | Thread address for fork, fork-and-stop and init |
| cmd_idx | input | IW = clog2(NCNT) | Counter index for post and init |
| cmd_count | input | CW | Initial count for init |
| next_valid | output | 1 | Registered dispatch strobe |
| next_pc | output | AW | Address of the thread to run next |
| frame_done | output | 1 | The dispatch is the frame-exit handler |
| overflow_err | output | 1 | A push was dropped because the stack was full |

## Verification
The assertions assume that only one command is accepted per cycle. They also assume that `cmd_idx` is below NCNT, since an index at or above NCNT would select a counter that does not exist. The bench drives one command per cycle through a task and sweeps every counter index of a four-counter configuration, so it never leaves these limits. The bench's stack and counter model follow the requirements alone. Fork depths, post counts and overflow cases are swept over the full depth of the small configuration.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_FORK  = 3'd1,
        OP_STOP  = 3'd2,
        OP_FSTOP = 3'd3,
        OP_POST  = 3'd4,
        OP_INIT  = 3'd5
    } fts_op_e;
endpackage

// File: rtl/fts_stack.sv
module fts_stack #(
    parameter int AW    = 12,
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [AW-1:0]             push_data,
    input  logic                      pop,
    output logic [AW-1:0]             top_data,
    output logic                      empty,
    output logic                      full,
    output logic [$clog2(DEPTH)-1:0]  depth
);
    localparam int SLOTS = DEPTH - 1;
    localparam int PW    = $clog2(DEPTH);

    typedef struct packed {
        logic [SLOTS-1:0][AW-1:0] mem;
        logic [PW-1:0]            cnt;
    } stk_t;

    stk_t s_d, s_q;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == PW'(SLOTS));
    assign depth = s_q.cnt;

    always_comb begin
        top_data = '0;
        if (!empty) begin
            top_data = s_q.mem[s_q.cnt - PW'(1)];
        end
    end

    always_comb begin
        s_d = s_q;
        if (push && !full) begin
            s_d.mem[s_q.cnt] = push_data;
            s_d.cnt          = s_q.cnt + PW'(1);
        end else if (pop && !empty) begin
            s_d.cnt = s_q.cnt - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/fts_sync.sv
module fts_sync #(
    parameter int AW   = 12,
    parameter int NCNT = 8,
    parameter int CW   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init,
    input  logic                     post,
    input  logic [$clog2(NCNT)-1:0]  idx,
    input  logic [CW-1:0]            load_count,
    input  logic [AW-1:0]            load_addr,
    output logic                     fire,
    output logic [AW-1:0]            fire_addr
);
    typedef struct packed {
        logic [NCNT-1:0][CW-1:0] cnt;
        logic [NCNT-1:0][AW-1:0] tgt;
    } sync_t;

    sync_t y_d, y_q;

    assign fire      = post && (y_q.cnt[idx] == CW'(1));
    assign fire_addr = y_q.tgt[idx];

    always_comb begin
        y_d = y_q;
        if (init) begin
            y_d.cnt[idx] = load_count;
            y_d.tgt[idx] = load_addr;
        end else if (post && (y_q.cnt[idx] != '0)) begin
            y_d.cnt[idx] = y_q.cnt[idx] - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q <= '0;
        end else begin
            y_q <= y_d;
        end
    end
endmodule

// File: rtl/frame_thread_sched.sv
module frame_thread_sched
    import fts_pkg::*;
#(
    parameter int          AW      = 12,
    parameter int          DEPTH   = 8,
    parameter int          NCNT    = 8,
    parameter int          CW      = 6,
    parameter logic [AW-1:0] EXIT_PC = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [AW-1:0]            cmd_addr,
    input  logic [$clog2(NCNT)-1:0]  cmd_idx,
    input  logic [CW-1:0]            cmd_count,
    output logic                     next_valid,
    output logic [AW-1:0]            next_pc,
    output logic                     frame_done,
    output logic                     overflow_err
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] pc;
        logic          done;
        logic          ovf;
    } out_t;

    out_t o_d, o_q;

    logic          is_fork, is_stop, is_fstop, is_post, is_init;
    logic          stk_push, stk_pop, stk_empty, stk_full;
    logic [AW-1:0] stk_top, push_val, fire_addr;
    logic          fire, push_req;
    logic [PW-1:0] stk_depth;

    always_comb begin
        is_fork  = cmd_valid && (cmd_op == OP_FORK);
        is_stop  = cmd_valid && (cmd_op == OP_STOP);
        is_fstop = cmd_valid && (cmd_op == OP_FSTOP);
        is_post  = cmd_valid && (cmd_op == OP_POST);
        is_init  = cmd_valid && (cmd_op == OP_INIT);
    end

    fts_sync #(.AW(AW), .NCNT(NCNT), .CW(CW)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (is_init),
        .post       (is_post),
        .idx        (cmd_idx),
        .load_count (cmd_count),
        .load_addr  (cmd_addr),
        .fire       (fire),
        .fire_addr  (fire_addr)
    );

    always_comb begin
        push_req = is_fork || fire;
        push_val = is_fork ? cmd_addr : fire_addr;
        stk_push = push_req && !stk_full;
        stk_pop  = is_stop && !stk_empty;
    end

    fts_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .push_data (push_val),
        .pop       (stk_pop),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .full      (stk_full),
        .depth     (stk_depth)
    );

    always_comb begin
        o_d       = '0;
        o_d.ovf   = push_req && stk_full;
        if (is_stop) begin
            o_d.valid = 1'b1;
            o_d.pc    = stk_empty ? EXIT_PC : stk_top;
            o_d.done  = stk_empty;
        end else if (is_fstop) begin
            o_d.valid = 1'b1;
            o_d.pc    = cmd_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign next_valid   = o_q.valid;
    assign next_pc      = o_q.pc;
    assign frame_done   = o_q.done;
    assign overflow_err = o_q.ovf;
endmodule

// File: rtl/frame_thread_sched_chk.sv
module frame_thread_sched_chk #(
    parameter int            AW      = 12,
    parameter int            DEPTH   = 8,
    parameter logic [AW-1:0] EXIT_PC = '1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [2:0]               cmd_op,
    input logic                     next_valid,
    input logic [AW-1:0]            next_pc,
    input logic                     frame_done,
    input logic                     overflow_err,
    input logic [$clog2(DEPTH)-1:0] depth
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] TOPD = PW'(DEPTH - 1);

    logic disp_cmd;
    assign disp_cmd = cmd_valid && ((cmd_op == 3'd2) || (cmd_op == 3'd3));

    p_fork_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && depth != TOPD) |=> (depth == $past(depth) + PW'(1)));

    p_stop_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2 && depth != '0) |=> (next_valid && depth == $past(depth) - PW'(1)));

    p_exit_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (next_valid && next_pc == EXIT_PC && depth == '0));

    p_overflow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |-> (depth == TOPD && $stable(depth)));

    p_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |=> (next_valid && $stable(depth)));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_cmd |=> !next_valid);
endmodule

bind frame_thread_sched frame_thread_sched_chk #(
    .AW(AW), .DEPTH(DEPTH), .EXIT_PC(EXIT_PC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .next_valid   (next_valid),
    .next_pc      (next_pc),
    .frame_done   (frame_done),
    .overflow_err (overflow_err),
    .depth        (stk_depth)
);

// File: tb/frame_thread_sched_tb.sv
module frame_thread_sched_tb;
    localparam int AW = 8, DEPTH = 4, NCNT = 4, CW = 4;
    localparam logic [7:0] EXIT_PC = 8'hF0;
    localparam int SLOTS = DEPTH - 1;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [1:0] cmd_idx = 0;
    logic [CW-1:0] cmd_count = 0;
    logic next_valid, frame_done, overflow_err;
    logic [AW-1:0] next_pc;

    int errors = 0, checks = 0;
    int mstk[$];
    int mcnt[NCNT];
    int mtgt[NCNT];

    always #2 clk = ~clk;

    frame_thread_sched #(.AW(AW), .DEPTH(DEPTH), .NCNT(NCNT), .CW(CW), .EXIT_PC(EXIT_PC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_idx(cmd_idx), .cmd_count(cmd_count),
        .next_valid(next_valid), .next_pc(next_pc),
        .frame_done(frame_done), .overflow_err(overflow_err)
    );

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmd(input bit v, input int op, input int addr, input int idx, input int cnt, input string req);
        int ev, epc, ed, eo, pushv;
        bit want_push;
        ev = 0; epc = 0; ed = 0; eo = 0; want_push = 0; pushv = 0;
        if (v) begin
            case (op)
                1: begin want_push = 1; pushv = addr; end
                2: begin
                    ev = 1;
                    if (mstk.size() == 0) begin epc = EXIT_PC; ed = 1; end
                    else epc = mstk.pop_back();
                end
                3: begin ev = 1; epc = addr; end
                4: if (mcnt[idx] != 0) begin
                    mcnt[idx]--;
                    if (mcnt[idx] == 0) begin want_push = 1; pushv = mtgt[idx]; end
                end
                5: begin mcnt[idx] = cnt; mtgt[idx] = addr; end
                default: ;
            endcase
            if (want_push) begin
                if (mstk.size() == SLOTS) eo = 1;
                else mstk.push_back(pushv);
            end
        end
        @(negedge clk);
        cmd_valid = v; cmd_op = 3'(op); cmd_addr = AW'(addr);
        cmd_idx = 2'(idx); cmd_count = CW'(cnt);
        @(posedge clk);
        #1;
        cmd_valid = 0;
        chk(next_valid == ev, req, "next_valid", int'(next_valid), ev);
        if (ev) chk(int'(next_pc) == epc, req, "next_pc", int'(next_pc), epc);
        chk(int'(frame_done) == ed, req, "frame_done", int'(frame_done), ed);
        chk(int'(overflow_err) == eo, req, "overflow_err", int'(overflow_err), eo);
    endtask

    initial begin
        for (int i = 0; i < NCNT; i++) begin mcnt[i] = 0; mtgt[i] = 0; end
        #9;
        // R10: reset state
        chk(next_valid == 0 && frame_done == 0 && overflow_err == 0, "R10", "outputs in reset", int'(next_valid), 0);
        rst_n = 1;
        cmd(1, 2, 0, 0, 0, "R10_R3");
        cmd(1, 2, 0, 0, 0, "R3");
        // R1 R2 R3: fork depths 0..SLOTS, then drain one past empty
        for (int n = 0; n <= SLOTS; n++) begin
            for (int k = 0; k < n; k++) cmd(1, 1, 16 * n + k + 1, 0, 0, "R1");
            for (int k = 0; k <= n; k++) cmd(1, 2, 0, 0, 0, "R2_R3");
        end
        // R8: fork into a full stack
        for (int k = 0; k < SLOTS; k++) cmd(1, 1, 8'h40 + k, 0, 0, "R1");
        cmd(1, 1, 8'h77, 0, 0, "R8");
        // R9: fork-and-stop bypasses stack
        cmd(1, 3, 8'h5A, 0, 0, "R9");
        for (int k = 0; k <= SLOTS; k++) cmd(1, 2, 0, 0, 0, "R8_R9");
        // R11: invalid command and no-op codes
        cmd(0, 1, 8'h33, 0, 0, "R11");
        cmd(1, 0, 8'h34, 0, 0, "R11");
        cmd(1, 6, 8'h35, 0, 0, "R11");
        cmd(1, 7, 8'h36, 0, 0, "R11");
        cmd(1, 2, 0, 0, 0, "R11");
        // R4 R5 R6 R7: every counter, counts 1..3
        for (int i = 0; i < NCNT; i++) begin
            for (int c = 1; c <= 3; c++) begin
                cmd(1, 5, 8'h80 + 8 * i + c, i, c, "R4");
                for (int p = 1; p < c; p++) begin
                    cmd(1, 4, 0, i, 0, "R6");
                    cmd(1, 2, 0, 0, 0, "R6");
                end
                cmd(1, 4, 0, i, 0, "R5");
                cmd(1, 4, 0, i, 0, "R7");
                cmd(1, 2, 0, 0, 0, "R5");
                cmd(1, 2, 0, 0, 0, "R7");
            end
        end
        // R8: post reaching zero on a full stack
        cmd(1, 5, 8'hC1, 2, 1, "R4");
        for (int k = 0; k < SLOTS; k++) cmd(1, 1, 8'h20 + k, 0, 0, "R1");
        cmd(1, 4, 0, 2, 0, "R8");
        cmd(1, 4, 0, 2, 0, "R8_R7");
        for (int k = 0; k <= SLOTS; k++) cmd(1, 2, 0, 0, 0, "R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule